// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Protocol Engine

This block is the protocol core of a two-wire serial EEPROM slave. It is given SCL and SDA levels that have already been filtered and synchronised to the system clock, along with one-cycle pulses that flag bus start and stop conditions. Its only bus output is an open-drain pull enable for SDA. Three strap inputs set the slave's bus address, and a lock input blocks all writes.

The engine decodes the device address word. It accepts byte and page writes into an eight-byte staging buffer and commits that buffer to its storage array during an internally timed write cycle. While that cycle runs it stays off the bus, so a master can poll for completion by sending the address word until the slave acknowledges it again. Reads can start at the current address, at a random address set by a dummy write, or continue sequentially. One pointer serves both reads and writes. After a read it wraps across the whole array. After a write it wraps within the page.

The storage array is either 256 or 512 bytes. In the larger build, the strap position that would carry A0 supplies memory address bit 8 instead.

Top module: `eep_slave`

## Requirements
- R1: The first byte after a start is the device word, sent MSB first. Bits 7..4 must be 1010. Bits 3, 2 and 1 are compared with strap bits 2, 1 and 0. Bit 0 set to 1 selects a read and set to 0 selects a write. On any mismatch the slave does not acknowledge and ignores all traffic until the next start.
- R2: With DEPTH=512, only device bits 3..2 are compared with straps 2..1. Device bit 1 of a write word becomes memory address bit 8, and strap bit 0 has no effect.
- R3: In a write transfer, the slave holds SDA low for the ninth clock after every byte it receives. In a read transfer, the device word is the only byte it acknowledges.
- R4: Read bytes are shifted out MSB first, and the slave changes SDA only while SCL is low.
- R5: After a read byte, the slave releases SDA for the ninth clock. If the master drives SDA low, the slave sends the next byte. If the master leaves SDA high, the slave keeps SDA released through any further clocks until a start or a stop.
- R6: A stop that follows at least one received data byte starts a write cycle lasting WC_CYCLES clocks. A stop after only the device word and the address byte starts no write cycle.
- R7: While a write cycle runs, the slave never pulls SDA low, so its device word is not acknowledged. After the cycle ends it acknowledges again.
- R8: A write word followed by an address byte and then a repeated start with a read word returns data starting at that address.
- R9: Each read byte advances the pointer by one. The pointer wraps from DEPTH-1 to 0, and a sequential read continues across the wrap.
- R10: Write data goes to pointer bits 2..0 within the current 8-byte page, and these bits wrap inside the page. A later byte overwrites an earlier byte at the same offset. After the write, a current-address read starts at the offset after the last byte written, within the same page.
- R11: If the lock input is high at the stop, no write cycle starts and memory is unchanged. Data bytes are still acknowledged.
- R12: After reset, SDA is released, no write cycle is running, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Filtered, synchronised SCL level |
| sda_i | input | 1 | Filtered, synchronised SDA level |
| start_pulse | input | 1 | One-cycle pulse on a start condition |
| stop_pulse | input | 1 | One-cycle pulse on a stop condition |
| addr_strap | input | 3 | Strapped bus address, bit 2 compared first |
| wr_lock | input | 1 | High blocks all array writes |
| sda_pull | output | 1 | High pulls SDA low (open drain) |

## Verification
The checker tests four rules on every clock. No pull is ever driven during a write cycle. The pull only rises while SCL is low. A write cycle begins only on a stop that arrives with the lock input low. The array is written only inside a write cycle. Everything that depends on data cannot be seen by these per-cycle checks, so the bench scenarios cover it. That includes in-page wrap and overwrite, where the pointer lands after reads and writes, wrap across the top of the array, the ninth address bit, and the released bus after a master's not-acknowledge. The bench compares each of these against a byte-level model of the array.

// File: rtl/eep_pkg.sv
// Shared constants and the bus-phase type of the EEPROM slave engine.
// Assumes a page of PAGE_BYTES bytes and a fixed 4-bit device code.
package eep_pkg;
    localparam logic [3:0] DEV_CODE   = 4'b1010;
    localparam int         PAGE_BYTES = 8;

    typedef enum logic [2:0] {
        PH_IDLE,    // not addressed, ignoring the bus
        PH_RXDEV,   // shifting in the device word
        PH_RXADR,   // shifting in the memory address byte
        PH_RXDAT,   // shifting in a write data byte
        PH_ACK,     // slave pulls SDA for the ninth clock
        PH_TX,      // slave shifting out a read byte
        PH_RACK,    // master acknowledge slot after a read byte
        PH_HOLD     // master declined; bus released until start/stop
    } eep_phase_t;
endpackage

// File: rtl/eep_store.sv
// Byte storage array with one write port and a registered read port.
// Assumes reads and writes are never needed in the same cycle.
module eep_store #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    // Array write port.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Registered read, held until the next read request.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= 8'h00;
        else if (re) rdata <= cells[raddr];
    end
endmodule

// File: rtl/eep_pagebuf.sv
// Page staging buffer: one slot per page offset with a valid mask.
// Assumes the clear and the load are never requested in the same cycle.
module eep_pagebuf #(
    parameter int PB = 8,
    localparam int OW = $clog2(PB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [OW-1:0] load_off,
    input  logic [7:0]    load_data,
    input  logic [OW-1:0] rd_off,
    output logic [7:0]    rd_data,
    output logic          rd_valid
);
    logic [7:0]    slot [PB];
    logic [PB-1:0] valid;

    // Slot data storage; a later byte at the same offset overwrites.
    always_ff @(posedge clk) begin
        if (load) slot[load_off] <= load_data;
    end

    // Valid mask: set by loads, cleared as a whole.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) valid <= '0;
        else if (load)     valid[load_off] <= 1'b1;
    end

    // Commit-side read of one slot.
    always_comb begin
        rd_data  = slot[rd_off];
        rd_valid = valid[rd_off];
    end
endmodule

// File: rtl/eep_wcycle.sv
// Internally timed write cycle: busy for WC_CYCLES clocks after go.
// The first PB busy cycles step a commit offset through the page.
// Assumes WC_CYCLES > PB.
module eep_wcycle #(
    parameter int WC_CYCLES = 300,
    parameter int PB = 8,
    localparam int OW = $clog2(PB),
    localparam int CW = $clog2(WC_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    output logic          busy,
    output logic          done,
    output logic          commit_en,
    output logic [OW-1:0] commit_off
);
    logic [CW-1:0] cnt;

    // Busy flag and cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            busy <= go;
            cnt  <= '0;
        end else if (done) begin
            busy <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Commit window and end-of-cycle strobe.
    always_comb begin
        done       = busy && (cnt == CW'(WC_CYCLES - 1));
        commit_en  = busy && (cnt < CW'(PB));
        commit_off = cnt[OW-1:0];
    end
endmodule

// File: rtl/eep_slave.sv
// Two-wire EEPROM slave protocol engine (top).
// Takes filtered SCL/SDA levels plus start/stop pulses and drives an
// open-drain SDA pull. Decodes the device word, runs page writes through
// a staging buffer and a timed write cycle, and serves current, random
// and sequential reads from one shared pointer.
// Assumes DEPTH is 256 or 512 and each SCL phase lasts >= 3 clocks.
module eep_slave #(
    parameter int DEPTH     = 512,
    parameter int WC_CYCLES = 300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       start_pulse,
    input  logic       stop_pulse,
    input  logic [2:0] addr_strap,
    input  logic       wr_lock,
    output logic       sda_pull
);
    import eep_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int PB = PAGE_BYTES;
    localparam int OW = $clog2(PB);
    localparam logic [2:0] CMP_MASK = (AW > 8) ? 3'b110 : 3'b111;

    eep_phase_t    ph, after_ack;
    logic          scl_q, rise, fall, in_rx, byte_done, quiet;
    logic [3:0]    cnt;
    logic [7:0]    sh, tx;
    logic [AW-1:0] ptr;
    logic          dev_a0, mack, got_data, dev_ok;
    logic          rd_fire, pb_load, pb_clr, wc_go;
    logic          wc_busy, wc_done, commit_en, pb_valid, mem_we;
    logic [OW-1:0] commit_off;
    logic [7:0]    pb_data, rd_data;

    // Event decode and per-cycle control strobes.
    always_comb begin
        rise      = scl_i & ~scl_q;
        fall      = ~scl_i & scl_q;
        in_rx     = (ph == PH_RXDEV) || (ph == PH_RXADR) || (ph == PH_RXDAT);
        byte_done = in_rx && fall && (cnt == 4'd8);
        quiet     = !wc_busy && !start_pulse && !stop_pulse;
        dev_ok    = (sh[7:4] == DEV_CODE) && (((sh[3:1] ^ addr_strap) & CMP_MASK) == 3'b000);
        rd_fire   = quiet && (((ph == PH_RXDEV) && byte_done && dev_ok && sh[0]) ||
                              ((ph == PH_RACK) && rise && !sda_i));
        pb_load   = quiet && (ph == PH_RXDAT) && byte_done;
        pb_clr    = (quiet && (ph == PH_RXADR) && byte_done) || wc_done;
        wc_go     = stop_pulse && !wc_busy && got_data && !wr_lock;
        mem_we    = commit_en && pb_valid;
        sda_pull  = (ph == PH_ACK) || ((ph == PH_TX) && !tx[7]);
    end

    // Bus phase machine, shift registers and the shared pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= PH_IDLE;
            after_ack <= PH_IDLE;
            scl_q     <= 1'b1;
            cnt       <= '0;
            sh        <= '0;
            tx        <= '0;
            ptr       <= '0;
            dev_a0    <= 1'b0;
            mack      <= 1'b1;
            got_data  <= 1'b0;
        end else begin
            scl_q <= scl_i;
            if (wc_busy || stop_pulse) begin
                ph       <= PH_IDLE;
                got_data <= 1'b0;
            end else if (start_pulse) begin
                ph       <= PH_RXDEV;
                cnt      <= '0;
                got_data <= 1'b0;
            end else begin
                if (rd_fire) ptr <= ptr + 1'b1;
                if (in_rx && rise && cnt != 4'd8) begin
                    sh  <= {sh[6:0], sda_i};
                    cnt <= cnt + 1'b1;
                end
                unique case (ph)
                    PH_RXDEV: if (byte_done) begin
                        cnt       <= '0;
                        dev_a0    <= sh[1];
                        ph        <= dev_ok ? PH_ACK : PH_IDLE;
                        after_ack <= sh[0] ? PH_TX : PH_RXADR;
                    end
                    PH_RXADR: if (byte_done) begin
                        cnt       <= '0;
                        ptr       <= AW'({dev_a0, sh});
                        ph        <= PH_ACK;
                        after_ack <= PH_RXDAT;
                    end
                    PH_RXDAT: if (byte_done) begin
                        cnt       <= '0;
                        ptr       <= {ptr[AW-1:OW], ptr[OW-1:0] + 1'b1};
                        got_data  <= 1'b1;
                        ph        <= PH_ACK;
                        after_ack <= PH_RXDAT;
                    end
                    PH_ACK: if (fall) begin
                        ph  <= after_ack;
                        cnt <= '0;
                        if (after_ack == PH_TX) tx <= rd_data;
                    end
                    PH_TX: if (fall) begin
                        if (cnt == 4'd7) begin
                            ph  <= PH_RACK;
                            cnt <= '0;
                        end else begin
                            tx  <= {tx[6:0], 1'b0};
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_RACK: begin
                        if (rise) mack <= sda_i;
                        if (fall) begin
                            if (!mack) begin
                                tx <= rd_data;
                                ph <= PH_TX;
                            end else begin
                                ph <= PH_HOLD;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    eep_pagebuf #(.PB(PB)) i_pagebuf (
        .clk(clk), .rst_n(rst_n), .clr(pb_clr), .load(pb_load),
        .load_off(ptr[OW-1:0]), .load_data(sh), .rd_off(commit_off),
        .rd_data(pb_data), .rd_valid(pb_valid)
    );

    eep_wcycle #(.WC_CYCLES(WC_CYCLES), .PB(PB)) i_wcycle (
        .clk(clk), .rst_n(rst_n), .go(wc_go), .busy(wc_busy), .done(wc_done),
        .commit_en(commit_en), .commit_off(commit_off)
    );

    eep_store #(.DEPTH(DEPTH)) i_store (
        .clk(clk), .rst_n(rst_n), .we(mem_we),
        .waddr({ptr[AW-1:OW], commit_off}), .wdata(pb_data),
        .re(rd_fire), .raddr(ptr), .rdata(rd_data)
    );
endmodule

// File: rtl/eep_slave_chk.sv
// Protocol checker for eep_slave, attached by bind.
// Watches the bus pins, the lock input and the internal busy and
// array-write strobes.
module eep_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic stop_pulse,
    input logic wr_lock,
    input logic sda_pull,
    input logic busy,
    input logic mem_we
);
    // R7: no acknowledge or data is driven during a write cycle.
    p_quiet_when_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull);

    // R4: the slave starts pulling SDA only while SCL is low.
    p_pull_in_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_i);

    // R6: a write cycle begins only on a stop.
    p_cycle_on_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_pulse));

    // R11: a write cycle never begins while the lock is high.
    p_lock_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wr_lock));

    // R6: the array is written only inside a write cycle.
    p_write_in_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);
endmodule

bind eep_slave eep_slave_chk i_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .stop_pulse(stop_pulse),
    .wr_lock(wr_lock), .sda_pull(sda_pull), .busy(wc_busy), .mem_we(mem_we)
);

// File: tb/test_eep_slave.sv
// Bench for eep_slave: bit-level master tasks, a byte model of the array,
// directed corner cases and seeded random page writes with read-back.
module test_eep_slave;
    localparam int DEPTH = 512;
    localparam int WC    = 300;
    localparam int H     = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, scl, m_sda, start_p, stop_p, wp;
    logic [2:0] strap;
    logic       sda_pull;
    wire        sda_bus = m_sda & ~sda_pull;

    int total = 0, bad = 0;
    bit done = 0;
    logic [7:0] model [DEPTH];
    bit         known [DEPTH];
    logic [7:0] wb [16];

    eep_slave #(.DEPTH(DEPTH), .WC_CYCLES(WC)) i_eep_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .start_pulse(start_p), .stop_pulse(stop_p), .addr_strap(strap),
        .wr_lock(wp), .sda_pull(sda_pull)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(H);
        scl = 1'b1;   tick(H);
        m_sda = 1'b0; start_p = 1'b1; tick(1); start_p = 1'b0;
        tick(H); scl = 1'b0;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(H);
        scl = 1'b1;   tick(H);
        m_sda = 1'b1; stop_p = 1'b1; tick(1); stop_p = 1'b0;
        tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(H);
            scl = 1'b1;   tick(H);
            scl = 1'b0;
        end
        m_sda = 1'b1; tick(H);
        scl = 1'b1;   tick(2);
        ack = sda_bus; tick(H - 2);
        scl = 1'b0;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; tick(H);
            scl = 1'b1;   tick(2);
            b[i] = sda_bus; tick(H - 2);
            scl = 1'b0;
        end
        m_sda = mack; tick(H);
        scl = 1'b1;   tick(H);
        scl = 1'b0;
    endtask

    function automatic logic [7:0] devw(input bit a0, input bit rd);
        return {4'b1010, 2'b10, a0, rd};
    endfunction

    // Page write of n bytes from wb[]; returns the count of refused bytes.
    task automatic page_write(input bit a0, input logic [7:0] adr, input int n, output int nacks);
        bit a;
        nacks = 0;
        bus_start();
        send_byte(devw(a0, 1'b0), a); nacks += a;
        send_byte(adr, a);            nacks += a;
        for (int i = 0; i < n; i++) begin
            send_byte(wb[i], a); nacks += a;
            if (!wp) begin
                model[{a0, adr[7:3], 3'(adr[2:0] + i)}] = wb[i];
                known[{a0, adr[7:3], 3'(adr[2:0] + i)}] = 1'b1;
            end
        end
        bus_stop();
    endtask

    task automatic poll(output bit ack);
        bus_start();
        send_byte(devw(1'b0, 1'b0), ack);
        bus_stop();
    endtask

    task automatic wait_ready(output int polls, output bit first_ack);
        bit a;
        polls = 0;
        do begin
            poll(a);
            if (polls == 0) first_ack = a;
            polls++;
        end while (a && polls < 60);
    endtask

    // Dummy write then repeated start with read; ok when all three acked.
    task automatic rand_read_open(input bit a0, input logic [7:0] adr, output bit ok);
        bit a1, a2, a3;
        bus_start();
        send_byte(devw(a0, 1'b0), a1);
        send_byte(adr, a2);
        bus_start();
        send_byte(devw(a0, 1'b1), a3);
        ok = !a1 && !a2 && !a3;
    endtask

    initial begin
        bit a, first, ok;
        int nk, polls;
        logic [7:0] b;
        void'($urandom(32'd4242));
        rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1; start_p = 1'b0; stop_p = 1'b0;
        wp = 1'b0; strap = 3'b100;
        tick(4);
        rst_n = 1'b1;
        tick(2);

        // R12: SDA released after reset and no write cycle pending
        chk(sda_bus == 1'b1, "R12 reset release", sda_bus, 1);
        poll(a);
        chk(a == 1'b0, "R12 idle acks", a, 0);

        // R1: wrong device code, then a following byte stays unacked
        bus_start();
        send_byte(8'b1011_1000, a);
        chk(a == 1'b1, "R1 bad code nack", a, 1);
        send_byte(8'h55, a);
        chk(a == 1'b1, "R1 idle after nack", a, 1);
        bus_stop();
        // R1: A2 strap mismatch, write and read
        bus_start();
        send_byte(8'b1010_0000, a);
        chk(a == 1'b1, "R1 strap mismatch w", a, 1);
        bus_stop();
        bus_start();
        send_byte(8'b1010_0101, a);
        chk(a == 1'b1, "R1 strap mismatch r", a, 1);
        bus_stop();

        // R10/R3: 10 bytes from offset 6 of page 0x08 wrap in the page
        for (int i = 0; i < 10; i++) wb[i] = 8'h10 + 8'(i);
        page_write(1'b0, 8'h0E, 10, nk);
        chk(nk == 0, "R3 write bytes acked", nk, 0);
        wait_ready(polls, first);
        chk(first == 1'b1, "R7 busy poll nacked", first, 1);
        chk(polls > 1 && polls < 60, "R7 ack after cycle", polls, 2);
        // R10: current address is offset 0 of the same page
        bus_start();
        send_byte(devw(1'b0, 1'b1), a);
        recv_byte(1'b1, b);
        bus_stop();
        chk(b == model[9'h008], "R10 current addr in page", b, model[9'h008]);
        chk(model[9'h008] == 8'h12, "R10 overwrite model", model[9'h008], 8'h12);

        // R2: device bit 1 is address bit 8; strap bit 0 irrelevant
        wb[0] = 8'h5A;
        page_write(1'b1, 8'h08, 1, nk);
        chk(nk == 0, "R2 a8 write acked", nk, 0);
        wait_ready(polls, first);
        rand_read_open(1'b1, 8'h08, ok);
        recv_byte(1'b1, b); bus_stop();
        chk(ok && b == 8'h5A, "R2 read a8=1", b, 8'h5A);
        rand_read_open(1'b0, 8'h08, ok);
        recv_byte(1'b1, b); bus_stop();
        chk(ok && b == model[9'h008], "R8 random read a8=0", b, model[9'h008]);

        // R9: sequential read wraps from 0x1FF to 0x000
        wb[0] = 8'hA1; wb[1] = 8'hA2;
        page_write(1'b1, 8'hFE, 2, nk); wait_ready(polls, first);
        wb[0] = 8'hB1; wb[1] = 8'hB2;
        page_write(1'b0, 8'h00, 2, nk); wait_ready(polls, first);
        rand_read_open(1'b1, 8'hFE, ok);
        chk(ok, "R8 dummy write acked", ok, 1);
        for (int i = 0; i < 4; i++) begin
            recv_byte(i == 3, b);
            chk(b == model[9'((9'h1FE + i) % DEPTH)], "R9 wrap read", b, model[9'((9'h1FE + i) % DEPTH)]);
        end
        // R5: after a master nack the bus stays released
        recv_byte(1'b1, b);
        chk(b == 8'hFF, "R5 released after nack", b, 8'hFF);
        bus_stop();

        // R6: address only, no data, starts no write cycle
        bus_start();
        send_byte(devw(1'b0, 1'b0), a);
        send_byte(8'h40, a);
        bus_stop();
        poll(a);
        chk(a == 1'b0, "R6 no cycle without data", a, 0);

        // R11: locked write is acked but leaves memory unchanged
        wp = 1'b1;
        for (int i = 0; i < 3; i++) wb[i] = 8'hEE;
        page_write(1'b0, 8'h08, 3, nk);
        chk(nk == 0, "R11 locked bytes acked", nk, 0);
        poll(a);
        chk(a == 1'b0, "R11 no cycle when locked", a, 0);
        wp = 1'b0;
        rand_read_open(1'b0, 8'h08, ok);
        recv_byte(1'b1, b); bus_stop();
        chk(b == model[9'h008], "R11 memory unchanged", b, model[9'h008]);

        // R10/R9: seeded random page writes with full-page read-back
        for (int it = 0; it < 16; it++) begin
            bit ra0;
            logic [7:0] radr;
            int n;
            ra0  = 1'($urandom);
            radr = 8'($urandom);
            n    = 1 + int'($urandom % 11);
            for (int i = 0; i < n; i++) wb[i] = 8'($urandom);
            page_write(ra0, radr, n, nk);
            chk(nk == 0, "R3 random write acked", nk, 0);
            wait_ready(polls, first);
            chk(polls < 60, "R7 random ready", polls, 2);
            rand_read_open(ra0, {radr[7:3], 3'b000}, ok);
            for (int i = 0; i < 8; i++) begin
                logic [8:0] ea;
                ea = {ra0, radr[7:3], 3'(i)};
                recv_byte(i == 7, b);
                if (known[ea]) chk(b == model[ea], "R10 random page data", b, model[ea]);
            end
            bus_stop();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule